// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes received Ethernet frames as a byte stream and places them in memory buffers. A ring of descriptors in that same memory describes the buffers. Software writes three words for each descriptor: a control/status word, a buffer size and a buffer address. It gives the descriptor to the engine by setting the owner bit, which is bit 31 of the control/status word. Software then programs the ring base, enables the receiver and issues a start command.

The engine walks the ring in index order and fetches one descriptor per frame. It packs the incoming bytes into 32-bit words in the buffer and then overwrites the control/status word. The new word carries the owner bit cleared, the segment and error flags, and the stored length. The length includes the four CRC bytes, because the stream carries them. Each completed frame produces a completion pulse.

If the engine fetches a descriptor that software still owns, it stops. It raises both a buffer-unavailable pulse and a process-stopped pulse, and a new start command resumes it at the same ring index. Clearing the enable bit lets the frame in progress finish, and the engine then stops with only the process-stopped pulse.

Top module: `rxring_dma`

## Requirements
- R1: After reset `rx_running`, `fin_ready`, `mem_req` and all three interrupt outputs are 0, and the ring index is 0.
- R2: A register write to offset 1 with bit 0 set starts the engine only when the receiver enable (offset 0, bit 0) is 1 and the engine is stopped. Otherwise the start write has no effect: `rx_running` and `fin_ready` stay 0 and no descriptor is touched. Offset 2 holds the ring base word address.
- R3: Descriptor i occupies words base+4i (control/status, bit 31 set means the engine owns it), base+4i+1 (buffer size in bytes, bits 15:0) and base+4i+2 (buffer word address). Only an owned descriptor receives a frame.
- R4: Frame byte k is stored in buffer word k/4 at bits 8*(k%4)+7 to 8*(k%4), so the order is little-endian. A final partial word is written with its unused upper lanes at zero.
- R5: On completion the control/status word is rewritten with the following fields: bit 31 = 0, bit 30 (first segment) = 1, bit 29 (last segment), bit 28 (error summary), bit 27 (length fault), bit 26 (receive error), bit 25 (CRC error), bits 24:16 = 0, and bits 15:0 = the stored byte count including CRC bytes. `irq_frame` pulses for one cycle after that write.
- R6: `fin_err[0]` with the last byte sets bit 26, and `fin_err[1]` sets bit 25. Bit 28 is set whenever any of bits 27, 26 or 25 is set.
- R7: A frame shorter than MIN_LEN (default 64) bytes that is not truncated sets bit 27. A frame of exactly MIN_LEN bytes does not.
- R8: The engine accepts bytes beyond the buffer size but discards them. No word past the buffer is written, the length equals the buffer size, bit 29 is cleared, and bits 27 and 28 are set.
- R9: Fetching a descriptor with bit 31 clear raises `irq_nobuf` and `irq_stop` in the same cycle and drops `rx_running`. No byte is accepted after that.
- R10: The ring index advances by one after each frame and wraps from RING-1 to 0. A restart after a stop resumes at the index of the descriptor that was refused.
- R11: If enable is cleared while running, the current frame completes normally. The engine then stops with `irq_stop` and without `irq_nobuf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 control, 1 start, 2 ring base |
| reg_wdata | input | 32 | Register write data |
| fin_valid | input | 1 | Frame byte valid |
| fin_data | input | 8 | Frame byte |
| fin_last | input | 1 | Marks the final byte of a frame |
| fin_err | input | 2 | Error causes, valid with the last byte: bit 0 receive error, bit 1 CRC error |
| fin_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read (read data returns next cycle) |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| irq_frame | output | 1 | Frame completed pulse |
| irq_nobuf | output | 1 | Buffer unavailable pulse |
| irq_stop | output | 1 | Engine stopped pulse |
| rx_running | output | 1 | Engine is walking the ring |

## Verification
The hardest situation to reach is the refusal at the ring boundary: the engine must wrap back to descriptor 0 and find it still owned by software. The bench gets there by giving exactly four descriptors to a four-entry ring and sending four frames. The fifth fetch wraps onto the already-completed descriptor 0. The refused descriptor is then handed back with a short buffer and a sentinel word placed past its end, so that one oversized frame exercises the restart index, truncation and the no-overwrite rule together. A mid-frame disable is reached by clearing enable as soon as `fin_ready` rises and before the first byte is sent.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_CTL,
        S_WT_CTL,
        S_RD_SIZE,
        S_WT_SIZE,
        S_RD_ADDR,
        S_WT_ADDR,
        S_RECV,
        S_WR_DATA,
        S_WR_STAT
    } rx_state_e;

    // status word field positions (software decodes these)
    localparam int B_OWN  = 31;
    localparam int B_FS   = 30;
    localparam int B_LS   = 29;
    localparam int B_ES   = 28;
    localparam int B_LF   = 27;
    localparam int B_RE   = 26;
    localparam int B_CE   = 25;

    // register offsets
    localparam logic [1:0] RA_CTRL  = 2'd0;
    localparam logic [1:0] RA_START = 2'd1;
    localparam logic [1:0] RA_BASE  = 2'd2;

endpackage

// File: rtl/rxd_regs.sv
module rxd_regs
    import rxd_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic          en_o,
    output logic          start_o,
    output logic [AW-1:0] base_o
);

    typedef struct packed {
        logic          en;
        logic          start;
        logic [AW-1:0] base;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wdata;

    assign unused_wdata = ^reg_wdata[31:AW];

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                RA_CTRL:  r_d.en    = reg_wdata[0];
                RA_START: r_d.start = reg_wdata[0];
                RA_BASE:  r_d.base  = reg_wdata[AW-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en_o    = r_q.en;
    assign start_o = r_q.start;
    assign base_o  = r_q.base;

endmodule

// File: rtl/rxd_packer.sv
module rxd_packer #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [7:0]       din,
    output logic [8*LANES-1:0] word_o,
    output logic [$clog2(LANES)-1:0] lane_o
);

    localparam int LW = $clog2(LANES);

    typedef struct packed {
        logic [8*LANES-1:0] acc;
        logic [LW-1:0]      lane;
    } pk_t;

    pk_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (clr) begin
            p_d = '0;
        end else if (push) begin
            p_d.acc[8*p_q.lane +: 8] = din;
            p_d.lane                 = p_q.lane + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign word_o = p_q.acc;
    assign lane_o = p_q.lane;

endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int AW      = 10,
    parameter int RING    = 64,
    parameter int MIN_LEN = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic          fin_valid,
    input  logic          fin_last,
    input  logic [1:0]    fin_err,
    output logic          fin_ready,
    output logic          pk_push,
    output logic          pk_clr,
    input  logic [31:0]   pk_word,
    input  logic [1:0]    pk_lane,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          irq_frame,
    output logic          irq_nobuf,
    output logic          irq_stop,
    output logic          running_o
);

    localparam int IW = (RING > 1) ? $clog2(RING) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(RING - 1);
    localparam logic [15:0]   MIN_B    = 16'(MIN_LEN);

    typedef struct packed {
        rx_state_e     st;
        logic [IW-1:0] idx;
        logic [15:0]   bsize;
        logic [AW-1:0] baddr;
        logic [13:0]   wofs;
        logic [15:0]   nbytes;
        logic          trunc;
        logic          last;
        logic [1:0]    errs;
        logic          irq_frame;
        logic          irq_nobuf;
        logic          irq_stop;
    } eng_t;

    eng_t e_d, e_q;

    logic [AW-1:0] desc_addr;
    logic          store;
    logic          runt;
    logic [31:0]   stat_word;
    logic          unused_rd;

    assign desc_addr = base_i + AW'({e_q.idx, 2'b00});
    assign store     = e_q.nbytes < e_q.bsize;
    assign runt      = !e_q.trunc && (e_q.nbytes < MIN_B);
    assign unused_rd = ^mem_rdata[30:16];

    always_comb begin
        stat_word         = '0;
        stat_word[B_FS]   = 1'b1;
        stat_word[B_LS]   = !e_q.trunc;
        stat_word[B_LF]   = e_q.trunc | runt;
        stat_word[B_RE]   = e_q.errs[0];
        stat_word[B_CE]   = e_q.errs[1];
        stat_word[B_ES]   = e_q.trunc | runt | (|e_q.errs);
        stat_word[15:0]   = e_q.nbytes;
    end

    always_comb begin
        e_d           = e_q;
        e_d.irq_frame = 1'b0;
        e_d.irq_nobuf = 1'b0;
        e_d.irq_stop  = 1'b0;
        fin_ready     = 1'b0;
        pk_push       = 1'b0;
        pk_clr        = 1'b0;
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = desc_addr;
        mem_wdata     = '0;
        case (e_q.st)
            S_IDLE: begin
                if (start_i && en_i) e_d.st = S_RD_CTL;
            end
            S_RD_CTL: begin
                mem_req    = 1'b1;
                e_d.nbytes = '0;
                e_d.wofs   = '0;
                e_d.trunc  = 1'b0;
                e_d.last   = 1'b0;
                e_d.errs   = '0;
                pk_clr     = 1'b1;
                e_d.st     = S_WT_CTL;
            end
            S_WT_CTL: begin
                if (mem_rdata[B_OWN]) begin
                    e_d.st = S_RD_SIZE;
                end else begin
                    e_d.irq_nobuf = 1'b1;
                    e_d.irq_stop  = 1'b1;
                    e_d.st        = S_IDLE;
                end
            end
            S_RD_SIZE: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + AW'(1);
                e_d.st   = S_WT_SIZE;
            end
            S_WT_SIZE: begin
                e_d.bsize = mem_rdata[15:0];
                e_d.st    = S_RD_ADDR;
            end
            S_RD_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + AW'(2);
                e_d.st   = S_WT_ADDR;
            end
            S_WT_ADDR: begin
                e_d.baddr = mem_rdata[AW-1:0];
                e_d.st    = S_RECV;
            end
            S_RECV: begin
                fin_ready = 1'b1;
                if (fin_valid) begin
                    pk_push = store;
                    if (store) e_d.nbytes = e_q.nbytes + 16'd1;
                    else       e_d.trunc  = 1'b1;
                    if (fin_last) begin
                        e_d.last = 1'b1;
                        e_d.errs = fin_err;
                        e_d.st   = (store || pk_lane != 2'd0) ? S_WR_DATA : S_WR_STAT;
                    end else if (store && pk_lane == 2'd3) begin
                        e_d.st = S_WR_DATA;
                    end
                end
            end
            S_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = e_q.baddr + AW'(e_q.wofs);
                mem_wdata = pk_word;
                pk_clr    = 1'b1;
                e_d.wofs  = e_q.wofs + 14'd1;
                e_d.st    = e_q.last ? S_WR_STAT : S_RECV;
            end
            S_WR_STAT: begin
                mem_req       = 1'b1;
                mem_we        = 1'b1;
                mem_wdata     = stat_word;
                e_d.irq_frame = 1'b1;
                e_d.idx       = (e_q.idx == LAST_IDX) ? '0 : e_q.idx + 1'b1;
                if (en_i) begin
                    e_d.st = S_RD_CTL;
                end else begin
                    e_d.st       = S_IDLE;
                    e_d.irq_stop = 1'b1;
                end
            end
            default: e_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{st: S_IDLE, default: '0};
        else        e_q <= e_d;
    end

    assign irq_frame = e_q.irq_frame;
    assign irq_nobuf = e_q.irq_nobuf;
    assign irq_stop  = e_q.irq_stop;
    assign running_o = e_q.st != S_IDLE;

    AST_FRAME_AFTER_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_frame |-> $past(e_q.st == S_WR_STAT && mem_we)); // R5
    AST_WRITE_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == S_WR_DATA) |-> ({e_q.wofs, 2'b00} < e_q.bsize)); // R8
    AST_NOBUF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nobuf |-> (irq_stop && !running_o)); // R9
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stop |-> (!running_o && !fin_ready)); // R11
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st != S_WR_STAT) |=> $stable(e_q.idx)); // R10

endmodule

// File: rtl/rxring_dma.sv
module rxring_dma #(
    parameter int AW      = 10,
    parameter int RING    = 64,
    parameter int MIN_LEN = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic          fin_valid,
    input  logic [7:0]    fin_data,
    input  logic          fin_last,
    input  logic [1:0]    fin_err,
    output logic          fin_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          irq_frame,
    output logic          irq_nobuf,
    output logic          irq_stop,
    output logic          rx_running
);

    logic          en;
    logic          start;
    logic [AW-1:0] base;
    logic          pk_push;
    logic          pk_clr;
    logic [31:0]   pk_word;
    logic [1:0]    pk_lane;

    rxd_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .en_o      (en),
        .start_o   (start),
        .base_o    (base)
    );

    rxd_packer #(.LANES(4)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pk_clr),
        .push   (pk_push),
        .din    (fin_data),
        .word_o (pk_word),
        .lane_o (pk_lane)
    );

    rxd_engine #(.AW(AW), .RING(RING), .MIN_LEN(MIN_LEN)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .start_i   (start),
        .base_i    (base),
        .fin_valid (fin_valid),
        .fin_last  (fin_last),
        .fin_err   (fin_err),
        .fin_ready (fin_ready),
        .pk_push   (pk_push),
        .pk_clr    (pk_clr),
        .pk_word   (pk_word),
        .pk_lane   (pk_lane),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .irq_frame (irq_frame),
        .irq_nobuf (irq_nobuf),
        .irq_stop  (irq_stop),
        .running_o (rx_running)
    );

endmodule

// File: tb/sim_rxring_dma.sv
module sim_rxring_dma;

    localparam int AW   = 10;
    localparam int RING = 4;
    localparam int BASE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          fin_valid = 1'b0;
    logic [7:0]    fin_data = '0;
    logic          fin_last = 1'b0;
    logic [1:0]    fin_err = '0;
    logic          fin_ready;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          irq_frame, irq_nobuf, irq_stop, rx_running;

    logic [31:0] mem [0:(1<<AW)-1];
    int checks = 0;
    int fails  = 0;
    int n_frame = 0, n_nobuf = 0, n_stop = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rxring_dma #(.AW(AW), .RING(RING), .MIN_LEN(64)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .fin_valid(fin_valid), .fin_data(fin_data),
        .fin_last(fin_last), .fin_err(fin_err), .fin_ready(fin_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_frame(irq_frame),
        .irq_nobuf(irq_nobuf), .irq_stop(irq_stop), .rx_running(rx_running)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_frame += int'(irq_frame);
            n_nobuf += int'(irq_nobuf);
            n_stop  += int'(irq_stop);
        end
    end

    function automatic int bufw(int i);
        return 256 + 64 * i;
    endfunction

    function automatic logic [31:0] exp_stat(bit ls, bit lf, bit re, bit ce, int len);
        return {1'b0, 1'b1, ls, (lf | re | ce), lf, re, ce, 9'd0, 16'(len)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_desc(input int i, input int size, input int buf_w);
        mem[BASE + 4*i]     = 32'h8000_0000;
        mem[BASE + 4*i + 1] = 32'(size);
        mem[BASE + 4*i + 2] = 32'(buf_w);
    endtask

    task automatic send_frame(input int n, input logic [7:0] seed, input logic [1:0] err);
        for (int k = 0; k < n; k++) begin
            fin_valid = 1'b1;
            fin_data  = seed + 8'(k);
            fin_last  = (k == n - 1);
            fin_err   = (k == n - 1) ? err : 2'b00;
            while (!fin_ready) @(negedge clk);
            @(negedge clk);
        end
        fin_valid = 1'b0; fin_last = 1'b0; fin_err = 2'b00;
        cycles(12);
    endtask

    task automatic check_buf(input int bw, input int n, input logic [7:0] seed, input string req);
        int bad = 0;
        logic [7:0] got = '0;
        for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = mem[bw + k/4][8*(k%4) +: 8];
            if (b != seed + 8'(k) && bad == 0) got = b;
            if (b != seed + 8'(k)) bad++;
        end
        check(bad == 0, req, 32'(got), 32'(bad));
    endtask

    task automatic t_reset();
        check(!rx_running && !fin_ready && !mem_req, "R1 idle outputs",
              {29'd0, rx_running, fin_ready, mem_req}, 32'd0);
        check(!irq_frame && !irq_nobuf && !irq_stop, "R1 irqs",
              {29'd0, irq_frame, irq_nobuf, irq_stop}, 32'd0);
    endtask

    task automatic t_good();
        reg_write(2'd2, 32'(BASE));
        reg_write(2'd0, 32'd1);
        reg_write(2'd1, 32'd1);
        cycles(2);
        check(rx_running == 1'b1, "R2 start runs", 32'(rx_running), 32'd1);
        send_frame(70, 8'h10, 2'b00);
        check(mem[BASE] == exp_stat(1, 0, 0, 0, 70), "R5 status good",
              mem[BASE], exp_stat(1, 0, 0, 0, 70));
        check_buf(bufw(0), 70, 8'h10, "R4 byte packing");
        check(n_frame == 1, "R5 irq_frame", 32'(n_frame), 32'd1);
        check(mem[BASE + 1] == 32'd200, "R3 size word kept", mem[BASE + 1], 32'd200);
    endtask

    task automatic t_errors();
        send_frame(66, 8'h40, 2'b10);
        check(mem[BASE + 4] == exp_stat(1, 0, 0, 1, 66), "R6 crc error",
              mem[BASE + 4], exp_stat(1, 0, 0, 1, 66));
        send_frame(64, 8'h80, 2'b01);
        check(mem[BASE + 8] == exp_stat(1, 0, 1, 0, 64), "R6 rx error, R7 min len not runt",
              mem[BASE + 8], exp_stat(1, 0, 1, 0, 64));
        send_frame(20, 8'hC0, 2'b00);
        check(mem[BASE + 12] == exp_stat(1, 1, 0, 0, 20), "R7 runt",
              mem[BASE + 12], exp_stat(1, 1, 0, 0, 20));
        check_buf(bufw(3), 20, 8'hC0, "R7 runt data");
    endtask

    task automatic t_nobuf();
        check(n_nobuf == 1 && n_stop == 1, "R9 nobuf and stop",
              {n_nobuf[15:0], n_stop[15:0]}, 32'h0001_0001);
        check(!rx_running && !fin_ready, "R9 stopped",
              {30'd0, rx_running, fin_ready}, 32'd0);
        check(n_frame == 4, "R10 four frames", 32'(n_frame), 32'd4);
    endtask

    task automatic t_trunc_wrap();
        set_desc(0, 80, bufw(0));
        mem[bufw(0) + 20] = 32'hDEAD_BEEF;
        reg_write(2'd1, 32'd1);
        send_frame(100, 8'h05, 2'b00);
        check(mem[BASE] == exp_stat(0, 1, 0, 0, 80), "R8 R10 truncated at index 0",
              mem[BASE], exp_stat(0, 1, 0, 0, 80));
        check_buf(bufw(0), 80, 8'h05, "R8 kept bytes");
        check(mem[bufw(0) + 20] == 32'hDEAD_BEEF, "R8 no write past buffer",
              mem[bufw(0) + 20], 32'hDEAD_BEEF);
        check(n_nobuf == 2 && !rx_running, "R9 second refusal",
              32'(n_nobuf), 32'd2);
    endtask

    task automatic t_start_disabled();
        reg_write(2'd0, 32'd0);
        set_desc(1, 200, bufw(1));
        reg_write(2'd1, 32'd1);
        cycles(6);
        check(!rx_running && !fin_ready, "R2 start ignored while disabled",
              {30'd0, rx_running, fin_ready}, 32'd0);
        check(mem[BASE + 4] == 32'h8000_0000, "R2 descriptor untouched",
              mem[BASE + 4], 32'h8000_0000);
    endtask

    task automatic t_disable_mid();
        int stops_before;
        stops_before = n_stop;
        set_desc(2, 200, bufw(2));
        reg_write(2'd0, 32'd1);
        reg_write(2'd1, 32'd1);
        while (!fin_ready) @(negedge clk);
        reg_write(2'd0, 32'd0);
        send_frame(65, 8'h33, 2'b00);
        check(mem[BASE + 4] == exp_stat(1, 0, 0, 0, 65), "R11 frame completes",
              mem[BASE + 4], exp_stat(1, 0, 0, 0, 65));
        check(mem[bufw(1) + 16] == {24'd0, 8'h33 + 8'd64}, "R4 partial word",
              mem[bufw(1) + 16], {24'd0, 8'h33 + 8'd64});
        check(n_stop == stops_before + 1 && n_nobuf == 2, "R11 stop without nobuf",
              {n_stop[15:0], n_nobuf[15:0]}, {16'(stops_before + 1), 16'd2});
        check(!rx_running && mem[BASE + 8] == 32'h8000_0000, "R11 next descriptor not used",
              mem[BASE + 8], 32'h8000_0000);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
        for (int i = 0; i < RING; i++) set_desc(i, 200, bufw(i));
        cycles(3);
        t_reset();
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_good();
        t_errors();
        t_nobuf();
        t_trunc_wrap();
        t_start_disabled();
        t_disable_mid();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

endmodule